// File: doc/BRIEF.md
# Sparse Circulant Matrix–Vector Multiplier

The block forms the product r = A·v, where A is a P×P binary circulant matrix with only a few ones per row and v is a length-P vector held in a word-organised memory of NB elements per word. A is supplied only as a short list of offsets, one for each one in its first row. Each offset x selects the rotated copy of v whose element n is v[(n + x) mod P]. The result is the element-wise sum of these rotated copies. The sum is taken modulo 2 (XOR) in binary mode and as wrapping EW-bit integer addition in integer mode.

A start pulse latches the mode and the number of offsets. The block first writes zeros into every valid element of the result memory. It then handles one offset at a time. For each offset it reads the source words starting at the word that holds element x and wrapping around the end of the vector. A small packing buffer realigns the elements into result-word order. The elements of the first word that lie below the start index are kept in a side register and supply the tail of the rotated copy. Every aligned result word is read, combined with the new elements and written back in the same cycle. When P is not a multiple of NB, the last word is partial. Its padding lanes are never read as data and never written.

Top module: `circ_vec_mult`

## Requirements
- R1: In binary mode (mode_int=0), element n of the result equals the XOR, over the first pos_cnt offsets read from pos_addr 0 upward, of source element (n + x) mod P. Element n sits in word n/NB, lane n%NB, bits [lane*EW +: EW]. Offsets lie in 0..P-1.
- R2: In integer mode (mode_int=1), element n of the result is the sum of the same source elements, modulo 2^EW.
- R3: Earlier result-memory contents never leak into the result. With pos_cnt=0, every valid result element reads zero when done rises.
- R4: A rotated copy wraps from element P-1 to element 0. The padding lanes of the partial last source word never reach the result.
- R5: Lanes of the last result word that map to elements at index P or above are never written (their res_we bit stays low).
- R6: An offset on a word boundary (x%NB=0) and the offset x=P-1 both give correct results.
- R7: busy is high from the cycle after an accepted start through the done cycle. done is high for exactly one cycle, the cycle after the final result write. A start pulse while busy is ignored.
- R8: During and right after reset, busy, done and all res_we bits are low.
- R9: A repeated offset cancels in binary mode and counts twice in integer mode.
- R10: done rises no later than NW + pos_cnt·(NW+4) + 2 cycles after the start cycle, where NW = ceil(P/NB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a product; sampled only while idle |
| mode_int | input | 1 | 0 = XOR accumulation, 1 = integer accumulation |
| pos_cnt | input | CW | Number of offsets to use (0..NPOS) |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle pulse after the last result write |
| pos_addr | output | PAW | Offset list read address |
| pos_data | input | PW | Offset list read data (combinational) |
| src_addr | output | WAW | Source word read address |
| src_data | input | NB*EW | Source word read data (combinational) |
| res_addr | output | WAW | Result word address, shared by read and write |
| res_we | output | NB | Per-lane result write enables |
| res_wdata | output | NB*EW | Result write data |
| res_rdata | input | NB*EW | Result read data (combinational) |

## Verification
The result is complete once the register edge that raises done has occurred, because the final write lands on that same edge. The scoreboard monitor therefore compares the whole result memory, including the untouched padding lanes, in the one cycle that done is high. The bench samples at the falling edge, half a cycle after each write. The driver counts falling edges from the start cycle to done and checks that count against the R10 bound. One falling edge later it checks that done and busy have both dropped.

// File: rtl/circ_mult_pkg.sv
package circ_mult_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_SETUP = 3'd2,
    ST_RUN   = 3'd3,
    ST_FIN   = 3'd4
  } seq_state_t;

  // bits needed to hold the values 0..n-1
  function automatic int bits_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int div_up(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/circ_mult_ctrl.sv
module circ_mult_ctrl
  import circ_mult_pkg::*;
#(
  parameter int P    = 13,
  parameter int NB   = 4,
  parameter int NPOS = 4,
  localparam int NW    = div_up(P, NB),
  localparam int LASTV = P - (NW - 1) * NB,
  localparam int WAW   = bits_for(NW),
  localparam int PW    = bits_for(P),
  localparam int PAW   = bits_for(NPOS),
  localparam int CW    = bits_for(NPOS + 1),
  localparam int LCW   = bits_for(NB + 1),
  localparam int FW    = bits_for(NW + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode_int,
  input  logic [CW-1:0]  pos_cnt,
  input  logic [PW-1:0]  pos_data,
  input  logic           emit,
  output logic           busy,
  output logic           done,
  output logic           mode_q,
  output logic           clear_o,
  output logic           run_o,
  output logic           setup_o,
  output logic [PAW-1:0] pos_addr,
  output logic [WAW-1:0] src_addr,
  output logic           feed_valid,
  output logic           use_saved,
  output logic           save_word,
  output logic [LCW-1:0] feed_lo,
  output logic [LCW-1:0] feed_hi,
  output logic [WAW-1:0] out_addr,
  output logic [LCW-1:0] out_len
);

  localparam logic [WAW-1:0] LAST_W = WAW'(NW - 1);
  localparam logic [LCW-1:0] FULL_L = LCW'(NB);
  localparam logic [LCW-1:0] TAIL_L = LCW'(LASTV);
  localparam logic [FW-1:0]  F_END  = FW'(NW);
  localparam logic [WAW:0]   NW_C   = (WAW + 1)'(NW);
  localparam logic [PW:0]    P_C    = (PW + 1)'(P);

  seq_state_t       state_q, state_d;
  logic [WAW-1:0]   k_q, k_d, w_q, w_d, i0_q, i0_d;
  logic [LCW-1:0]   j_q, j_d;
  logic [FW-1:0]    f_q, f_d;
  logic [PAW-1:0]   sidx_q, sidx_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             mode_d;
  int               pos_i;

  function automatic logic [LCW-1:0] word_len(input logic [WAW-1:0] w);
    return (w == LAST_W) ? TAIL_L : FULL_L;
  endfunction

  function automatic logic [WAW-1:0] next_w(input logic [WAW-1:0] w);
    return (w == LAST_W) ? '0 : w + 1'b1;
  endfunction

  assign pos_i = int'(pos_data);

  // next-state process
  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    f_d     = f_q;
    w_d     = w_q;
    i0_d    = i0_q;
    j_d     = j_q;
    sidx_d  = sidx_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CLEAR;
          k_d     = '0;
          cnt_d   = pos_cnt;
          mode_d  = mode_int;
        end
      end
      ST_CLEAR: begin
        k_d = k_q + 1'b1;
        if (k_q == LAST_W) begin
          k_d     = '0;
          sidx_d  = '0;
          state_d = (cnt_q == '0) ? ST_FIN : ST_SETUP;
        end
      end
      ST_SETUP: begin
        i0_d    = WAW'(pos_i / NB);
        j_d     = LCW'(pos_i % NB);
        w_d     = next_w(i0_d);
        f_d     = '0;
        k_d     = '0;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        if (f_q <= F_END) f_d = f_q + 1'b1;
        if ((f_q != '0) && (f_q < F_END)) w_d = next_w(w_q);
        if (emit) begin
          k_d = k_q + 1'b1;
          if (k_q == LAST_W) begin
            k_d = '0;
            if (CW'(sidx_q) + CW'(1) == cnt_q) begin
              state_d = ST_FIN;
            end else begin
              sidx_d  = sidx_q + 1'b1;
              state_d = ST_SETUP;
            end
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      f_q     <= '0;
      w_q     <= '0;
      i0_q    <= '0;
      j_q     <= '0;
      sidx_q  <= '0;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
      f_q     <= f_d;
      w_q     <= w_d;
      i0_q    <= i0_d;
      j_q     <= j_d;
      sidx_q  <= sidx_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  // feed selection: first word from the start index, whole words, then the kept head
  always_comb begin
    feed_valid = 1'b0;
    use_saved  = 1'b0;
    save_word  = 1'b0;
    feed_lo    = '0;
    feed_hi    = '0;
    src_addr   = w_q;
    if (state_q == ST_RUN) begin
      if (f_q == '0) begin
        src_addr   = i0_q;
        feed_lo    = j_q;
        feed_hi    = word_len(i0_q);
        save_word  = 1'b1;
        feed_valid = 1'b1;
      end else if (f_q < F_END) begin
        feed_hi    = word_len(w_q);
        feed_valid = 1'b1;
      end else if (f_q == F_END) begin
        use_saved  = 1'b1;
        feed_hi    = j_q;
        feed_valid = 1'b1;
      end
    end
  end

  assign out_addr = k_q;
  assign out_len  = word_len(k_q);
  assign pos_addr = sidx_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign clear_o  = (state_q == ST_CLEAR);
  assign run_o    = (state_q == ST_RUN);
  assign setup_o  = (state_q == ST_SETUP);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R7
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> ({1'b0, pos_data} < P_C));  // R1
  AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> ({1'b0, src_addr} < NW_C));  // R4

endmodule

// File: rtl/circ_mult_collapse.sv
module circ_mult_collapse
  import circ_mult_pkg::*;
#(
  parameter int NB = 4,
  parameter int EW = 8,
  localparam int BUFN = 2 * NB,
  localparam int LW   = bits_for(NB),
  localparam int BIW  = bits_for(BUFN),
  localparam int LCW  = bits_for(NB + 1),
  localparam int BCW  = bits_for(BUFN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             want,
  input  logic             feed_valid,
  input  logic             use_saved,
  input  logic             save_word,
  input  logic [NB*EW-1:0] src_word,
  input  logic [LCW-1:0]   feed_lo,
  input  logic [LCW-1:0]   feed_hi,
  input  logic [LCW-1:0]   out_len,
  output logic             emit,
  output logic [NB*EW-1:0] out_word
);

  logic [NB*EW-1:0] saved_q;
  logic [EW-1:0]    lane_src [NB];
  logic [EW-1:0]    lane_sav [NB];
  logic [EW-1:0]    buf_q    [BUFN];
  logic [EW-1:0]    buf_d    [BUFN];
  logic [EW-1:0]    merged   [BUFN];
  logic [BCW-1:0]   cnt_q, cnt_d, avail;
  logic [LCW-1:0]   in_len;
  logic             buf_en;
  int               src_idx;
  int               sh;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_src[g] = src_word[g*EW +: EW];
    assign lane_sav[g] = saved_q[g*EW +: EW];
    assign out_word[g*EW +: EW] = merged[g];
  end

  // append the selected lanes behind the buffered elements
  always_comb begin
    in_len = feed_valid ? (feed_hi - feed_lo) : '0;
    avail  = cnt_q + BCW'(in_len);
    for (int i = 0; i < BUFN; i++) begin
      merged[i] = '0;
      src_idx   = i - int'(cnt_q) + int'(feed_lo);
      if (i < int'(cnt_q)) begin
        merged[i] = buf_q[i];
      end else if ((i - int'(cnt_q)) < int'(in_len) && src_idx < NB) begin
        merged[i] = use_saved ? lane_sav[LW'(src_idx)] : lane_src[LW'(src_idx)];
      end
    end
    emit = want && (avail >= BCW'(out_len));
  end

  // drop the emitted elements from the front
  always_comb begin
    for (int i = 0; i < BUFN; i++) begin
      sh       = i + int'(out_len);
      buf_d[i] = merged[i];
      if (emit) buf_d[i] = (sh < BUFN) ? merged[BIW'(sh)] : '0;
    end
    if (clr)       cnt_d = '0;
    else if (emit) cnt_d = avail - BCW'(out_len);
    else           cnt_d = avail;
  end

  assign buf_en = feed_valid || emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (buf_en) begin
      for (int i = 0; i < BUFN; i++) buf_q[i] <= buf_d[i];
    end
    if (save_word) saved_q <= src_word;
  end

  AST_BUF_BELOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < BCW'(NB));  // R4

endmodule

// File: rtl/circ_mult_accum.sv
module circ_mult_accum #(
  parameter int NB = 4,
  parameter int EW = 8
) (
  input  logic             mode_int,
  input  logic [NB*EW-1:0] acc_word,
  input  logic [NB*EW-1:0] add_word,
  output logic [NB*EW-1:0] sum_word
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [EW-1:0] a, b;
    assign a = acc_word[g*EW +: EW];
    assign b = add_word[g*EW +: EW];
    assign sum_word[g*EW +: EW] = mode_int ? (a + b) : (a ^ b);
  end

endmodule

// File: rtl/circ_vec_mult.sv
module circ_vec_mult
  import circ_mult_pkg::*;
#(
  parameter int P    = 13,
  parameter int NB   = 4,
  parameter int EW   = 8,
  parameter int NPOS = 4,
  localparam int NW    = div_up(P, NB),
  localparam int LASTV = P - (NW - 1) * NB,
  localparam int WAW   = bits_for(NW),
  localparam int PW    = bits_for(P),
  localparam int PAW   = bits_for(NPOS),
  localparam int CW    = bits_for(NPOS + 1),
  localparam int LCW   = bits_for(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_int,
  input  logic [CW-1:0]    pos_cnt,
  output logic             busy,
  output logic             done,
  output logic [PAW-1:0]   pos_addr,
  input  logic [PW-1:0]    pos_data,
  output logic [WAW-1:0]   src_addr,
  input  logic [NB*EW-1:0] src_data,
  output logic [WAW-1:0]   res_addr,
  output logic [NB-1:0]    res_we,
  output logic [NB*EW-1:0] res_wdata,
  input  logic [NB*EW-1:0] res_rdata
);

  localparam logic [WAW-1:0] LAST_W    = WAW'(NW - 1);
  localparam logic [NB-1:0]  TAIL_MASK = NB'((64'd1 << LASTV) - 64'd1);

  logic             mode_q, clear_p, run_p, setup_p, emit;
  logic             feed_valid, use_saved, save_word;
  logic [LCW-1:0]   feed_lo, feed_hi, out_len;
  logic [WAW-1:0]   out_addr;
  logic [NB*EW-1:0] aligned, sum_word;
  logic [NB-1:0]    lane_mask;

  circ_mult_ctrl #(.P(P), .NB(NB), .NPOS(NPOS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_int(mode_int),
    .pos_cnt(pos_cnt), .pos_data(pos_data), .emit(emit),
    .busy(busy), .done(done), .mode_q(mode_q),
    .clear_o(clear_p), .run_o(run_p), .setup_o(setup_p),
    .pos_addr(pos_addr), .src_addr(src_addr),
    .feed_valid(feed_valid), .use_saved(use_saved), .save_word(save_word),
    .feed_lo(feed_lo), .feed_hi(feed_hi),
    .out_addr(out_addr), .out_len(out_len)
  );

  circ_mult_collapse #(.NB(NB), .EW(EW)) u_collapse (
    .clk(clk), .rst_n(rst_n), .clr(setup_p), .want(run_p),
    .feed_valid(feed_valid), .use_saved(use_saved), .save_word(save_word),
    .src_word(src_data), .feed_lo(feed_lo), .feed_hi(feed_hi),
    .out_len(out_len), .emit(emit), .out_word(aligned)
  );

  circ_mult_accum #(.NB(NB), .EW(EW)) u_accum (
    .mode_int(mode_q), .acc_word(res_rdata), .add_word(aligned),
    .sum_word(sum_word)
  );

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign lane_mask[g] = (LCW'(g) < out_len);
  end

  assign res_addr  = out_addr;
  assign res_we    = (clear_p || emit) ? lane_mask : '0;
  assign res_wdata = clear_p ? '0 : sum_word;

  AST_NO_PAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_addr == LAST_W) |-> ((res_we & ~TAIL_MASK) == '0));  // R5
  AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (res_we == '0));  // R8

endmodule

// File: tb/circ_vec_mult_tb.sv
`timescale 1ns/1ps
module circ_vec_mult_tb;
  import circ_mult_pkg::*;

  localparam int P    = 13;
  localparam int NB   = 4;
  localparam int EW   = 8;
  localparam int NPOS = 4;
  localparam int NW   = div_up(P, NB);
  localparam int WAW  = bits_for(NW);
  localparam int PW   = bits_for(P);
  localparam int PAW  = bits_for(NPOS);
  localparam int CW   = bits_for(NPOS + 1);
  localparam logic [EW-1:0] SENT = 8'hA5;
  localparam logic [EW-1:0] PADV = 8'hEE;

  logic             clk = 1'b0;
  logic             rst_n, start, mode_int;
  logic [CW-1:0]    pos_cnt;
  logic             busy, done;
  logic [PAW-1:0]   pos_addr;
  logic [PW-1:0]    pos_data;
  logic [WAW-1:0]   src_addr, res_addr;
  logic [NB*EW-1:0] src_data, res_wdata, res_rdata;
  logic [NB-1:0]    res_we;

  logic [PW-1:0]    pos_mem [NPOS];
  logic [NB*EW-1:0] src_mem [NW];
  logic [NB*EW-1:0] res_mem [NW];

  int checks = 0;
  int errors = 0;
  logic [P*EW-1:0] exp_q[$];
  string           tag_q[$];

  always #10 clk = ~clk;

  circ_vec_mult u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_int(mode_int),
    .pos_cnt(pos_cnt), .busy(busy), .done(done),
    .pos_addr(pos_addr), .pos_data(pos_data),
    .src_addr(src_addr), .src_data(src_data),
    .res_addr(res_addr), .res_we(res_we), .res_wdata(res_wdata),
    .res_rdata(res_rdata)
  );

  assign pos_data  = pos_mem[pos_addr];
  assign src_data  = src_mem[src_addr];
  assign res_rdata = res_mem[res_addr];

  always @(posedge clk) begin
    for (int g = 0; g < NB; g++)
      if (res_we[g]) res_mem[res_addr][g*EW +: EW] <= res_wdata[g*EW +: EW];
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  // monitor: compares the result memory in the done cycle
  always @(negedge clk) begin : monitor
    logic [P*EW-1:0] e;
    string           t;
    logic [EW-1:0]   got, want;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 done without pending product", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int n = 0; n < P; n++) begin
          got  = res_mem[n / NB][(n % NB)*EW +: EW];
          want = e[n*EW +: EW];
          check(got == want, $sformatf("%s element %0d", t, n), int'(got), int'(want));
        end
        for (int n = P; n < NW * NB; n++) begin
          got = res_mem[n / NB][(n % NB)*EW +: EW];
          check(got == SENT, $sformatf("R5 padding lane %0d written", n), int'(got), int'(SENT));
        end
      end
    end
  end

  // driver: fills memories, predicts the product, runs one start/done
  task automatic run_case(input logic m, input int c, input int q0, input int q1,
                          input int q2, input int q3, input int seed, input bit poke,
                          input string tag);
    int pl[4];
    logic [EW-1:0] v [P];
    logic [P*EW-1:0] e;
    logic [EW-1:0] a;
    int cyc;
    int bound;
    bit seen;
    pl = '{q0, q1, q2, q3};
    for (int n = 0; n < P; n++)
      v[n] = m ? EW'((n*29 + seed*13 + 5) % 256) : EW'(((n*7 + seed) % 3) == 0);
    for (int w = 0; w < NW; w++) begin
      for (int g = 0; g < NB; g++) begin
        src_mem[w][g*EW +: EW] = (w*NB + g < P) ? v[w*NB + g] : PADV;
        res_mem[w][g*EW +: EW] = SENT;
      end
    end
    for (int i = 0; i < NPOS; i++) pos_mem[i] = PW'(pl[i]);
    for (int n = 0; n < P; n++) begin
      a = '0;
      for (int i = 0; i < c; i++)
        a = m ? (a + v[(n + pl[i]) % P]) : (a ^ v[(n + pl[i]) % P]);
      e[n*EW +: EW] = a;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bound = NW + c*(NW + 4) + 2;

    @(negedge clk);
    start = 1'b1; mode_int = m; pos_cnt = CW'(c);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    cyc  = 1;
    seen = 1'b0;
    while (!seen && cyc < 4 * bound) begin
      if (done) seen = 1'b1;
      else begin
        if (poke && cyc == 3) begin
          start = 1'b1; mode_int = ~m; pos_cnt = '0;
        end
        @(negedge clk);
        start = 1'b0; mode_int = m;
        cyc++;
      end
    end
    check(seen, "R7 done reached", int'(seen), 1);
    check(cyc <= bound, "R10 latency bound", cyc, bound);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    check(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; start = 1'b0; mode_int = 1'b0; pos_cnt = '0;
    for (int i = 0; i < NPOS; i++) pos_mem[i] = '0;
    for (int w = 0; w < NW; w++) begin
      src_mem[w] = '0;
      res_mem[w] = '0;
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 busy in reset", int'(busy), 0);
    check(done == 1'b0, "R8 done in reset", int'(done), 0);
    check(res_we == '0, "R8 res_we in reset", int'(res_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
    check(res_we == '0, "R8 res_we after reset", int'(res_we), 0);

    run_case(1'b0, 2,  2,  5,  0,  0, 1, 1'b0, "R1 binary offsets 2 and 5");
    run_case(1'b0, 3,  0,  4, 12,  0, 2, 1'b0, "R6 R4 binary aligned and last offsets");
    run_case(1'b1, 4, 10,  3,  7, 11, 3, 1'b0, "R2 R4 integer four offsets");
    run_case(1'b1, 3, 10,  3,  7,  0, 4, 1'b1, "R7 integer with start while busy");
    run_case(1'b1, 2,  6,  6,  0,  0, 5, 1'b0, "R9 integer repeated offset");
    run_case(1'b0, 2,  9,  9,  0,  0, 6, 1'b0, "R9 binary repeated offset cancels");
    run_case(1'b1, 0,  0,  0,  0,  0, 7, 1'b0, "R3 no offsets clears result");
    run_case(1'b0, 1, 12,  0,  0,  0, 8, 1'b0, "R6 R4 binary single last offset");

    check(exp_q.size() == 0, "R7 every product completed", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule